// File: doc/BRIEF.md
# Burst-of-two QDR SRAM controller

This block sits on the host side of a double-data-rate SRAM with separate read and write data buses and a burst length of two. A user issues writes and reads through two independent valid/ready command ports. Each write carries a 36-bit word (two 18-bit beats, first beat in the low half) and a per-lane enable. Each read returns a 36-bit word, again with the first beat in the low half, together with a one-cycle valid strobe. Responses come back in request order.

The device clocks are modelled as phase slots of a fabric clock running at twice the device rate. The output `sram_k` gives the K level for the current slot, so the rising edge of K falls at the end of a slot where `sram_k` is 0, and the rising edge of K# falls at the end of a slot where `sram_k` is 1. One device cycle is two fabric cycles. A read and a write can both be accepted in the same device cycle: the read address uses the bus in the slot before K rises, and the write address uses it in the slot before K# rises. A mode input picks where read data is captured. In single-clock mode the returned data follows K. In the default mode it follows a separate output clock that trails K by `C_LAG` fabric slots.

Top module: `qdr_b2_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after any reset edge, `sram_rd_n` and `sram_wr_n` are high, `rsp_valid` is low and both readies are low. No read already in flight produces a response after reset.
- R2: `rd_ready` and `wr_ready` are equal. They are high in alternate fabric cycles, and only in a cycle whose slot has `sram_k` = 1. A command is accepted at the clock edge that ends a cycle where its valid and ready are both high.
- R3: In the cycle after a write is accepted, `sram_k` = 0, `sram_wr_n` = 0, `sram_d` carries `wr_data[17:0]`, and `sram_bw_n[i]` = NOT `wr_lane_en[i]`.
- R4: In the cycle after that, `sram_k` = 1, `sram_addr` carries the write address and `sram_d` carries `wr_data[35:18]`.
- R5: Lane 0 is data bits 8:0 of each beat, and lane 1 is bits 17:9. `sram_bw_n` is active low, with bit i for lane i. It holds the same value for both beats of a write. A lane whose enable is 0 leaves both stored beats of that lane unchanged. In a K-low slot with no write, every bit of `sram_bw_n` is high.
- R6: In the cycle after a read is accepted, `sram_rd_n` = 0 and `sram_addr` carries the read address. If a write is accepted in the same cycle, the read address takes the K-low slot and the write address takes the following K-high slot.
- R7: With `single_clk_mode` = 0, `rsp_valid` is high exactly 6 + `C_LAG` fabric cycles after the edge that accepts a read. `rsp_data[17:0]` is the beat on `sram_q` sampled `C_LAG`+5 edges after acceptance, and `rsp_data[35:18]` is the beat sampled one edge later.
- R8: With `single_clk_mode` = 1, the same holds with a latency of 6 cycles. The first beat is sampled 5 edges after acceptance and the second beat 6 edges after.
- R9: Without an accepted read, `rsp_valid` stays low whatever `sram_q` carries.
- R10: Reads accepted in consecutive device cycles return in request order, one response every two fabric cycles, and `rsp_valid` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, twice the device clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| single_clk_mode | input | 1 | 1: read data follows K; 0: read data follows the lagging output clock |
| wr_valid | input | 1 | Write command valid |
| wr_ready | output | 1 | Write command accepted this cycle if valid |
| wr_addr | input | ADDR_W (19) | Write location |
| wr_data | input | 2*BEAT_W (36) | Write word; low half is the first beat |
| wr_lane_en | input | LANES (2) | Active-high lane enables, applied to both beats |
| rd_valid | input | 1 | Read command valid |
| rd_ready | output | 1 | Read command accepted this cycle if valid |
| rd_addr | input | ADDR_W (19) | Read location |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_data | output | 2*BEAT_W (36) | Read word; low half is the first beat |
| sram_k | output | 1 | K level of the current slot |
| sram_rd_n | output | 1 | Active-low read select |
| sram_wr_n | output | 1 | Active-low write select |
| sram_addr | output | ADDR_W (19) | Shared address bus |
| sram_d | output | BEAT_W (18) | Write data beat |
| sram_bw_n | output | LANES (2) | Active-low lane write enables |
| sram_q | input | BEAT_W (18) | Read data beat from the device |

## Verification
A wrong slot phase shows one fabric cycle after any accepted command: the select or the write address lands in the wrong `sram_k` slot, so the device model stores or fetches the wrong location. A wrong tap in the read pipeline moves `rsp_valid` away from the expected latency, or swaps or repeats beats in `rsp_data`. This shows on the first read after the fault, 6 or 7 cycles after acceptance. A stale lane register or a stale busy flag corrupts only the masked lanes, and that appears at the next read of the location.

// File: rtl/qdr_b2_pkg.sv
// Shared definitions for the burst-of-two SRAM controller.
// Assumes one device cycle equals two fabric cycles (two phase slots).
package qdr_b2_pkg;

    // Phase slot of the device clock during one fabric cycle.
    typedef enum logic {
        SLOT_K_LOW  = 1'b0,
        SLOT_K_HIGH = 1'b1
    } slot_e;

    // Pipeline taps, counted in edges after read acceptance minus one,
    // for the first and second returned beats with no output-clock lag.
    localparam int unsigned BEAT0_TAP = 4;
    localparam int unsigned BEAT1_TAP = 5;

endpackage

// File: rtl/qdr_b2_cmd_seq.sv
// Command sequencer: owns the phase slot and drives selects and address.
// Commands are taken only in a K-high slot. The selects and the read (or
// write) address appear in the next K-low slot, and the write address in
// the K-high slot after that. The write word and lanes are held for the
// beat packer. Assumes the read and write ports are independent.
module qdr_b2_cmd_seq
    import qdr_b2_pkg::*;
#(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned BEAT_W = 18,
    parameter int unsigned LANES  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_valid,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [2*BEAT_W-1:0]   wr_data,
    input  logic [LANES-1:0]      wr_lane_en,
    input  logic                  rd_valid,
    input  logic [ADDR_W-1:0]     rd_addr,
    output slot_e                 slot,
    output logic                  cmd_ready,
    output logic                  rd_issue,
    output logic                  sel_rd_n,
    output logic                  sel_wr_n,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [2*BEAT_W-1:0]   hold_data,
    output logic [LANES-1:0]      hold_lanes,
    output logic                  wr_busy,
    output logic                  beat_sel
);

    logic [ADDR_W-1:0] hold_addr;

    // Commands are taken at the edge that ends a K-high slot.
    assign cmd_ready = (slot == SLOT_K_HIGH);
    assign rd_issue  = cmd_ready && rd_valid;

    // Advance the slot and drive the device-side command fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot     <= SLOT_K_LOW;
            sel_rd_n <= 1'b1;
            sel_wr_n <= 1'b1;
            bus_addr <= '0;
            wr_busy  <= 1'b0;
            beat_sel <= 1'b0;
        end else if (slot == SLOT_K_HIGH) begin
            slot     <= SLOT_K_LOW;
            sel_rd_n <= ~rd_valid;
            sel_wr_n <= ~wr_valid;
            wr_busy  <= wr_valid;
            beat_sel <= 1'b0;
            bus_addr <= rd_valid ? rd_addr : wr_addr;
        end else begin
            slot     <= SLOT_K_HIGH;
            sel_rd_n <= 1'b1;
            sel_wr_n <= 1'b1;
            beat_sel <= 1'b1;
            bus_addr <= hold_addr;
        end
    end

    // Hold the accepted write for the second slot of its device cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_addr  <= '0;
            hold_data  <= '0;
            hold_lanes <= '0;
        end else if (cmd_ready && wr_valid) begin
            hold_addr  <= wr_addr;
            hold_data  <= wr_data;
            hold_lanes <= wr_lane_en;
        end
    end

endmodule

// File: rtl/qdr_b2_lane_pack.sv
// Beat packer: picks the first or second write beat for the data bus and
// forms the active-low lane enables. Lanes split each beat into equal
// slices, lowest lane in the lowest bits. Assumes BEAT_W divides by LANES.
module qdr_b2_lane_pack #(
    parameter int unsigned BEAT_W = 18,
    parameter int unsigned LANES  = 2
) (
    input  logic [2*BEAT_W-1:0] hold_data,
    input  logic [LANES-1:0]    hold_lanes,
    input  logic                wr_busy,
    input  logic                beat_sel,
    output logic [BEAT_W-1:0]   sram_d,
    output logic [LANES-1:0]    sram_bw_n
);

    localparam int unsigned LANE_W = BEAT_W / LANES;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Select this lane's slice of the current beat.
        assign sram_d[l*LANE_W +: LANE_W] = beat_sel
            ? hold_data[BEAT_W + l*LANE_W +: LANE_W]
            : hold_data[l*LANE_W +: LANE_W];
        // Enable the lane only while a write occupies the device cycle.
        assign sram_bw_n[l] = ~(hold_lanes[l] & wr_busy);
    end

endmodule

// File: rtl/qdr_b2_rd_track.sv
// Read tracker: a shift register marks every accepted read. Two taps,
// chosen by the clock mode, capture the first and second returned beats.
// The second tap raises the response strobe. Assumes a fixed device read
// latency and an output clock that lags K by C_LAG slots in dual-clock mode.
module qdr_b2_rd_track
    import qdr_b2_pkg::*;
#(
    parameter int unsigned BEAT_W = 18,
    parameter int unsigned C_LAG  = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                single_clk_mode,
    input  logic                rd_issue,
    input  logic [BEAT_W-1:0]   sram_q,
    output logic                rsp_valid,
    output logic [2*BEAT_W-1:0] rsp_data
);

    localparam int unsigned PIPE_D = BEAT1_TAP + 1 + C_LAG;

    logic [PIPE_D-1:0] pipe;
    logic [BEAT_W-1:0] first_beat;
    logic              tap0;
    logic              tap1;

    // Pick the capture taps for the selected clock mode.
    always_comb begin
        tap0 = single_clk_mode ? pipe[BEAT0_TAP] : pipe[BEAT0_TAP + C_LAG];
        tap1 = single_clk_mode ? pipe[BEAT1_TAP] : pipe[BEAT1_TAP + C_LAG];
    end

    // Shift the outstanding-read markers.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[PIPE_D-2:0], rd_issue};
    end

    // Capture both beats and strobe the assembled word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_beat <= '0;
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
        end else begin
            rsp_valid <= tap1;
            if (tap0) first_beat <= sram_q;
            if (tap1) rsp_data   <= {sram_q, first_beat};
        end
    end

endmodule

// File: rtl/qdr_b2_ctrl.sv
// Top of the burst-of-two SRAM controller. Connects the command sequencer,
// beat packer and read tracker. Assumes clk runs at twice the device clock
// and that sram_k is used to make the device K and K# edges.
module qdr_b2_ctrl
    import qdr_b2_pkg::*;
#(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned BEAT_W = 18,
    parameter int unsigned LANES  = 2,
    parameter int unsigned C_LAG  = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                single_clk_mode,
    input  logic                wr_valid,
    output logic                wr_ready,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [2*BEAT_W-1:0] wr_data,
    input  logic [LANES-1:0]    wr_lane_en,
    input  logic                rd_valid,
    output logic                rd_ready,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic                rsp_valid,
    output logic [2*BEAT_W-1:0] rsp_data,
    output logic                sram_k,
    output logic                sram_rd_n,
    output logic                sram_wr_n,
    output logic [ADDR_W-1:0]   sram_addr,
    output logic [BEAT_W-1:0]   sram_d,
    output logic [LANES-1:0]    sram_bw_n,
    input  logic [BEAT_W-1:0]   sram_q
);

    slot_e                slot;
    logic                 cmd_ready;
    logic                 rd_issue;
    logic [2*BEAT_W-1:0]  hold_data;
    logic [LANES-1:0]     hold_lanes;
    logic                 wr_busy;
    logic                 beat_sel;

    assign sram_k   = (slot == SLOT_K_HIGH);
    assign wr_ready = cmd_ready;
    assign rd_ready = cmd_ready;

    qdr_b2_cmd_seq #(
        .ADDR_W (ADDR_W),
        .BEAT_W (BEAT_W),
        .LANES  (LANES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_lane_en (wr_lane_en),
        .rd_valid   (rd_valid),
        .rd_addr    (rd_addr),
        .slot       (slot),
        .cmd_ready  (cmd_ready),
        .rd_issue   (rd_issue),
        .sel_rd_n   (sram_rd_n),
        .sel_wr_n   (sram_wr_n),
        .bus_addr   (sram_addr),
        .hold_data  (hold_data),
        .hold_lanes (hold_lanes),
        .wr_busy    (wr_busy),
        .beat_sel   (beat_sel)
    );

    qdr_b2_lane_pack #(
        .BEAT_W (BEAT_W),
        .LANES  (LANES)
    ) u_pack (
        .hold_data  (hold_data),
        .hold_lanes (hold_lanes),
        .wr_busy    (wr_busy),
        .beat_sel   (beat_sel),
        .sram_d     (sram_d),
        .sram_bw_n  (sram_bw_n)
    );

    qdr_b2_rd_track #(
        .BEAT_W (BEAT_W),
        .C_LAG  (C_LAG)
    ) u_track (
        .clk             (clk),
        .rst_n           (rst_n),
        .single_clk_mode (single_clk_mode),
        .rd_issue        (rd_issue),
        .sram_q          (sram_q),
        .rsp_valid       (rsp_valid),
        .rsp_data        (rsp_data)
    );

endmodule

// File: rtl/qdr_b2_ctrl_chk.sv
// Protocol checker for qdr_b2_ctrl, attached by bind below.
// Checks slot discipline, command placement and response spacing at the ports.
module qdr_b2_ctrl_chk #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sram_k,
    input logic              sram_rd_n,
    input logic              sram_wr_n,
    input logic [LANES-1:0]  sram_bw_n,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              rsp_valid
);

    // R1: a reset cycle leaves selects idle and no response.
    p_idle_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (sram_rd_n && sram_wr_n && !rsp_valid));

    // R2: readiness alternates with the slot.
    p_ready_alternates_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |=> !rd_ready);

    // R3: selects only ever appear in a K-low slot.
    p_sel_in_klow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_wr_n || !sram_rd_n) |-> !sram_k);

    // R3: an accepted write drives its select in the next cycle.
    p_wr_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !sram_wr_n);

    // R4: the write address follows one slot later.
    p_wr_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> ##1 (sram_addr == $past(wr_addr, 2)));

    // R5: no lane is enabled in a K-low slot without a write.
    p_lane_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_wr_n && !sram_k) |-> (&sram_bw_n));

    // R6: an accepted read drives its select and address next cycle.
    p_rd_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready) |=> (!sram_rd_n && sram_addr == $past(rd_addr)));

    // R10: responses are single-cycle strobes.
    p_rsp_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

bind qdr_b2_ctrl qdr_b2_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sram_k    (sram_k),
    .sram_rd_n (sram_rd_n),
    .sram_wr_n (sram_wr_n),
    .sram_bw_n (sram_bw_n),
    .sram_addr (sram_addr),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .rsp_valid (rsp_valid)
);

// File: tb/qdr_b2_ctrl_tb_top.sv
// Directed bench for qdr_b2_ctrl with a behavioural burst-of-two SRAM model.
module qdr_b2_ctrl_tb_top;

    localparam int unsigned ADDR_W = 19;
    localparam int unsigned BEAT_W = 18;
    localparam int unsigned LANES  = 2;
    localparam int unsigned C_LAG  = 1;
    localparam logic [17:0] JUNK   = 18'h2A5A5;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                single_clk_mode = 1'b0;
    logic                wr_valid = 1'b0;
    logic                wr_ready;
    logic [ADDR_W-1:0]   wr_addr = '0;
    logic [2*BEAT_W-1:0] wr_data = '0;
    logic [LANES-1:0]    wr_lane_en = '0;
    logic                rd_valid = 1'b0;
    logic                rd_ready;
    logic [ADDR_W-1:0]   rd_addr = '0;
    logic                rsp_valid;
    logic [2*BEAT_W-1:0] rsp_data;
    logic                sram_k;
    logic                sram_rd_n;
    logic                sram_wr_n;
    logic [ADDR_W-1:0]   sram_addr;
    logic [BEAT_W-1:0]   sram_d;
    logic [LANES-1:0]    sram_bw_n;
    logic [BEAT_W-1:0]   sram_q = '0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    qdr_b2_ctrl #(
        .ADDR_W (ADDR_W), .BEAT_W (BEAT_W), .LANES (LANES), .C_LAG (C_LAG)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .single_clk_mode (single_clk_mode),
        .wr_valid (wr_valid), .wr_ready (wr_ready), .wr_addr (wr_addr),
        .wr_data (wr_data), .wr_lane_en (wr_lane_en),
        .rd_valid (rd_valid), .rd_ready (rd_ready), .rd_addr (rd_addr),
        .rsp_valid (rsp_valid), .rsp_data (rsp_data),
        .sram_k (sram_k), .sram_rd_n (sram_rd_n), .sram_wr_n (sram_wr_n),
        .sram_addr (sram_addr), .sram_d (sram_d), .sram_bw_n (sram_bw_n),
        .sram_q (sram_q)
    );

    // ---------------- behavioural SRAM model ----------------
    logic [17:0] mem0 [int];
    logic [17:0] mem1 [int];
    logic [17:0] sched_d [32];
    bit          sched_v [32];
    int          mt = 0;
    bit          wpend = 0;
    logic [17:0] wb0;
    logic [1:0]  wbw;

    function automatic logic [17:0] lane_merge(input logic [17:0] old_v,
                                               input logic [17:0] new_v,
                                               input logic [1:0] bw_n);
        logic [17:0] r = old_v;
        if (!bw_n[0]) r[8:0]  = new_v[8:0];
        if (!bw_n[1]) r[17:9] = new_v[17:9];
        return r;
    endfunction

    always @(posedge clk) begin
        int lag;
        int a;
        lag = single_clk_mode ? 0 : C_LAG;
        if (sched_v[mt % 32]) begin
            sram_q <= sched_d[mt % 32];
            sched_v[mt % 32] = 1'b0;
        end else begin
            sram_q <= JUNK;
        end
        if (!sram_k) begin
            if (!sram_wr_n) begin
                wpend = 1'b1;
                wb0   = sram_d;
                wbw   = sram_bw_n;
            end
            if (!sram_rd_n) begin
                a = int'(sram_addr);
                sched_d[(mt + 3 + lag) % 32] = mem0.exists(a) ? mem0[a] : 18'h0;
                sched_v[(mt + 3 + lag) % 32] = 1'b1;
                sched_d[(mt + 4 + lag) % 32] = mem1.exists(a) ? mem1[a] : 18'h0;
                sched_v[(mt + 4 + lag) % 32] = 1'b1;
            end
        end else if (wpend) begin
            a = int'(sram_addr);
            mem0[a] = lane_merge(mem0.exists(a) ? mem0[a] : 18'h0, wb0, wbw);
            mem1[a] = lane_merge(mem1.exists(a) ? mem1[a] : 18'h0, sram_d, wbw);
            wpend = 1'b0;
        end
        mt++;
    end

    // ---------------- response monitor ----------------
    logic [35:0] rsp_log [64];
    int          rsp_cyc [64];
    int          rsp_cnt = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rsp_valid && rsp_cnt < 64) begin
            rsp_log[rsp_cnt] = rsp_data;
            rsp_cyc[rsp_cnt] = cyc;
            rsp_cnt++;
        end
    end

    // ---------------- checking helpers ----------------
    function automatic void finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
            finish_run();
        end
    end

    function automatic logic [35:0] merge36(input logic [35:0] old_v,
                                            input logic [35:0] new_v,
                                            input logic [1:0] lanes);
        logic [35:0] r = old_v;
        if (lanes[0]) begin r[8:0]   = new_v[8:0];   r[26:18] = new_v[26:18]; end
        if (lanes[1]) begin r[17:9]  = new_v[17:9];  r[35:27] = new_v[35:27]; end
        return r;
    endfunction

    task automatic wait_ready();
        @(negedge clk);
        while (!rd_ready) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(sram_rd_n == 1'b1, "R1 rd_n in reset", sram_rd_n, 1);
        chk(sram_wr_n == 1'b1, "R1 wr_n in reset", sram_wr_n, 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", rsp_valid, 0);
        chk(rd_ready == 1'b0 && wr_ready == 1'b0, "R1 ready in reset",
            {rd_ready, wr_ready}, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_ready_alternates();
        logic r0;
        logic r1;
        @(negedge clk);
        r0 = rd_ready;
        chk(rd_ready == wr_ready, "R2 ready pair", rd_ready, wr_ready);
        @(negedge clk);
        r1 = rd_ready;
        chk(r0 != r1, "R2 ready alternates", r1, ~r0);
        if (r1) chk(sram_k == 1'b1, "R2 ready in K-high", sram_k, 1);
        else    chk(r0 && sram_k == 1'b0, "R2 ready in K-high", sram_k, 0);
    endtask

    task automatic do_write(input logic [18:0] a, input logic [35:0] d,
                            input logic [1:0] lanes);
        wait_ready();
        wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_lane_en = lanes;
        @(negedge clk);
        wr_valid = 1'b0;
        chk(sram_wr_n == 1'b0 && sram_k == 1'b0, "R3 write select in K-low",
            {sram_wr_n, sram_k}, 0);
        chk(sram_d == d[17:0], "R3 first beat", sram_d, d[17:0]);
        chk(sram_bw_n == ~lanes, "R5 lane enables", sram_bw_n, ~lanes);
        @(negedge clk);
        chk(sram_k == 1'b1 && sram_addr == a, "R4 write address in K-high",
            sram_addr, a);
        chk(sram_d == d[35:18], "R4 second beat", sram_d, d[35:18]);
        chk(sram_bw_n == ~lanes, "R5 lanes held for second beat", sram_bw_n, ~lanes);
    endtask

    task automatic do_read(input logic [18:0] a, input logic [35:0] exp,
                           input string tag);
        int n0;
        int acc;
        int lat;
        lat = single_clk_mode ? 6 : 6 + C_LAG;
        wait_ready();
        rd_valid = 1'b1; rd_addr = a;
        n0 = rsp_cnt;
        @(negedge clk);
        rd_valid = 1'b0;
        acc = cyc;
        chk(sram_rd_n == 1'b0 && sram_addr == a, "R6 read select and address",
            sram_addr, a);
        for (int i = 0; i < 20 && rsp_cnt == n0; i++) begin
            @(negedge clk);
            #1;
        end
        chk(rsp_cnt > n0, {tag, " response present"}, rsp_cnt, n0 + 1);
        if (rsp_cnt > n0) begin
            chk(rsp_cyc[n0] - acc == lat, {tag, " latency"}, rsp_cyc[n0] - acc, lat);
            chk(rsp_log[n0] == exp, {tag, " data"}, rsp_log[n0], exp);
        end
    endtask

    task automatic t_read_and_write(input logic [18:0] ra, input logic [35:0] rexp,
                                    input logic [18:0] wa, input logic [35:0] wd);
        int n0;
        wait_ready();
        rd_valid = 1'b1; rd_addr = ra;
        wr_valid = 1'b1; wr_addr = wa; wr_data = wd; wr_lane_en = 2'b11;
        n0 = rsp_cnt;
        @(negedge clk);
        rd_valid = 1'b0; wr_valid = 1'b0;
        chk(!sram_rd_n && !sram_wr_n && sram_addr == ra, "R6 shared slot read address",
            sram_addr, ra);
        @(negedge clk);
        chk(sram_addr == wa, "R6 write address follows read", sram_addr, wa);
        repeat (10) @(negedge clk);
        #1;
        chk(rsp_cnt == n0 + 1 && rsp_log[n0] == rexp, "R6 read beside write data",
            rsp_log[n0], rexp);
    endtask

    task automatic t_burst(input logic [18:0] a0, input logic [18:0] a1,
                           input logic [18:0] a2, input logic [35:0] e0,
                           input logic [35:0] e1, input logic [35:0] e2);
        int n0;
        logic [18:0] addrs [3];
        addrs[0] = a0; addrs[1] = a1; addrs[2] = a2;
        n0 = rsp_cnt;
        for (int i = 0; i < 3; i++) begin
            wait_ready();
            rd_valid = 1'b1; rd_addr = addrs[i];
            @(negedge clk);
            rd_valid = 1'b0;
        end
        repeat (12) @(negedge clk);
        #1;
        chk(rsp_cnt == n0 + 3, "R10 burst response count", rsp_cnt - n0, 3);
        chk(rsp_log[n0] == e0, "R10 burst first in order", rsp_log[n0], e0);
        chk(rsp_log[n0+1] == e1, "R10 burst second in order", rsp_log[n0+1], e1);
        chk(rsp_log[n0+2] == e2, "R10 burst third in order", rsp_log[n0+2], e2);
        chk(rsp_cyc[n0+1] - rsp_cyc[n0] == 2 && rsp_cyc[n0+2] - rsp_cyc[n0+1] == 2,
            "R10 burst spacing", rsp_cyc[n0+2] - rsp_cyc[n0], 4);
    endtask

    task automatic t_idle(input int n);
        int n0;
        n0 = rsp_cnt;
        repeat (n) @(negedge clk);
        #1;
        chk(rsp_cnt == n0, "R9 no response without read", rsp_cnt, n0);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        logic [35:0] v1, v2, v3, n1, n2;
        v1 = 36'h1_2345_6789;
        v2 = 36'hF_EDCB_A987;
        v3 = 36'h5_A5A5_3C3C;
        n1 = 36'h0_0FF0_1FF1;
        n2 = 36'hA_BCDE_F012;

        t_reset_state();
        t_ready_alternates();
        do_write(19'h00010, v1, 2'b11);
        do_write(19'h7FFFF, v2, 2'b11);
        t_idle(16);
        do_read(19'h00010, v1, "R7 read dual-clock");
        do_read(19'h7FFFF, v2, "R7 read top address");
        do_write(19'h00010, n1, 2'b01);
        v1 = merge36(v1, n1, 2'b01);
        do_read(19'h00010, v1, "R5 lane 0 only");
        do_write(19'h7FFFF, n2, 2'b10);
        v2 = merge36(v2, n2, 2'b10);
        do_read(19'h7FFFF, v2, "R5 lane 1 only");
        do_write(19'h7FFFF, n1, 2'b00);
        do_read(19'h7FFFF, v2, "R5 no lane leaves word");
        t_read_and_write(19'h00010, v1, 19'h00333, v3);
        do_read(19'h00333, v3, "R6 written beside read");
        t_burst(19'h00010, 19'h7FFFF, 19'h00333, v1, v2, v3);
        t_idle(20);

        single_clk_mode = 1'b1;
        t_reset_state();
        do_read(19'h00010, v1, "R8 read single-clock");
        t_burst(19'h00333, 19'h00010, 19'h7FFFF, v3, v1, v2);
        do_read(19'h12345, 36'h0, "R8 unwritten location");
        t_idle(20);

        finish_run();
    end

endmodule